// File: doc/BRIEF.md
# Carry-less and Binary-Field Multiplier

This unit does polynomial arithmetic over GF(2), one operation at a time. For two 64-bit operands it forms the 128-bit carry-less product and returns the low half, the high half, or a window shifted down by one bit (bits 126 down to 63). It can also work in a small binary field GF(2^m): the degree m and the reducing polynomial are supplied with each request. In that mode it either multiplies two elements or adds them, and both results are reduced modulo the supplied polynomial.

A request is issued by raising `start` for one cycle with `op`, the operands, `modulus` and `degree` valid. The unit then works alone until it raises `done` for one cycle. `result` keeps its value until the next completion. Every multiply, plain or field, uses one shift-and-XOR step per cycle. The field multiply reduces the accumulator at each step, so the accumulator never grows past degree m. The field add, a field reduction when the first operand is zero, finishes in a single cycle.

Top module: `polymul_unit`

## Requirements
- R1: With `op`=0, `result` is bits 63..0 of the carry-less product of `a` and `b` (the XOR over every set bit i of `b` of `a` shifted left by i). `done` rises 65 rising edges after the edge that samples `start`, counting that edge as the first.
- R2: With `op`=1, `result` is bits 127..64 of that product, with the same 65-edge latency.
- R3: With `op`=2, `result` is bits 126..63 of that product, with the same 65-edge latency.
- R4: With `op`=3, `result` is (a[15:0] · b[15:0]) mod P, where the product is carry-less and P is the effective polynomial of R6. Operands at or above 2^m are therefore reduced. The result is below 2^m. `done` rises m+1 edges after the sampling edge, counting that edge as the first. Examples: m=3, P=0xB gives 7·5=6; m=8, P=0x11B gives 0x80·0x83=0x01.
- R5: With `op`=4, `result` is (a[15:0] XOR b[15:0]) mod P, so with `a`=0 the unit performs a pure reduction. `done` rises on the sampling edge itself, a latency of 1, and `busy` stays low.
- R6: The effective degree m is `degree` when that value lies between 1 and 8, and 8 otherwise. The effective polynomial P has bit m set, takes bits m-1..0 from `modulus`, and ignores the bits of `modulus` above m.
- R7: While `busy` is high, `start` is ignored: the running operation completes with its own result and latency, and no extra `done` appears.
- R8: `done` is high for exactly one cycle per accepted request. `result` changes only on the edge that raises `done` and holds its value afterwards. `busy` is high from the sampling edge until the completion edge of a multiply, and `busy` and `done` are never high together.
- R9: After reset, `busy`, `done` and `result` are all zero.
- R10: `op` values 5, 6 and 7 complete with latency 1 and a zero `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when not busy |
| op | input | 3 | 0 low, 1 high, 2 shifted window, 3 field multiply, 4 field add |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| modulus | input | 9 | Reducing polynomial; bit m implied, bits above m ignored |
| degree | input | 4 | Field degree m, 1..8 (other values mean 8) |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Last completed result |

## Verification
Latencies are counted in rising edges, and the edge that samples `start` counts as the first. A carry-less multiply completes on edge 65, a field multiply on edge m+1, and a field add or reserved code on edge 1. Stimulus is driven on falling edges. After `start` drops, the bench counts falling edges until `done` is seen. It compares that count with the latency the requirement gives, then checks `result` against an independent long-division model. On the falling edge after completion it confirms that `done` has fallen and that `result` has held. The busy-ignore case issues a field add partway through a carry-less multiply. It then requires no `done` until edge 65 and requires the carry-less result.

// File: rtl/polymul_unit.sv
module polymul_unit #(
  parameter int XLEN  = 64,
  parameter int GFMAX = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [2:0]                   op,
  input  logic [XLEN-1:0]              a,
  input  logic [XLEN-1:0]              b,
  input  logic [GFMAX:0]               modulus,
  input  logic [$clog2(GFMAX+1)-1:0]   degree,
  output logic                         busy,
  output logic                         done,
  output logic [XLEN-1:0]              result
);
  localparam int DW   = $clog2(GFMAX + 1);
  localparam int CW   = $clog2(XLEN + 1);
  localparam int GFIN = 2 * GFMAX;
  localparam logic [2:0] OP_LO = 3'd0, OP_HI = 3'd1, OP_REV = 3'd2,
                         OP_GFMUL = 3'd3, OP_GFADD = 3'd4;

  function automatic logic [GFMAX:0] gf_reduce(input logic [GFIN-1:0] v,
                                               input logic [DW-1:0] m,
                                               input logic [GFMAX:0] p);
    logic [GFMAX:0] r;
    r = '0;
    for (int i = GFIN - 1; i >= 0; i--) begin
      r = {r[GFMAX-1:0], v[i]};
      if (r[m]) r = r ^ p;
    end
    return r;
  endfunction

  logic [2*XLEN-1:0] acc, acc_sh, acc_nx;
  logic [XLEN-1:0]   opa, opb, sel;
  logic [2:0]        op_q;
  logic [DW-1:0]     m_q, deg_eff;
  logic [GFMAX:0]    poly_q, poly_in, lowmask, sh_low, red_a, red_b;
  logic [CW-1:0]     cnt;

  assign deg_eff = (degree == '0 || degree > DW'(GFMAX)) ? DW'(GFMAX) : degree;

  always_comb begin
    lowmask = (GFMAX+1)'((1 << deg_eff) - 1);
    poly_in = (modulus & lowmask) | ((GFMAX+1)'(1) << deg_eff);
  end

  assign red_a = gf_reduce(a[GFIN-1:0], deg_eff, poly_in);
  assign red_b = gf_reduce(b[GFIN-1:0], deg_eff, poly_in);

  always_comb begin
    acc_sh = acc << 1;
    sh_low = acc_sh[GFMAX:0];
    if (op_q == OP_GFMUL && sh_low[m_q]) acc_sh = acc_sh ^ (2*XLEN)'(poly_q);
    acc_nx = acc_sh ^ (opb[XLEN-1] ? {{XLEN{1'b0}}, opa} : '0);
  end

  always_comb begin
    case (op_q)
      OP_HI:   sel = acc_nx[2*XLEN-1:XLEN];
      OP_REV:  sel = acc_nx[2*XLEN-2:XLEN-1];
      default: sel = acc_nx[XLEN-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      acc    <= '0;
      opa    <= '0;
      opb    <= '0;
      op_q   <= OP_LO;
      m_q    <= '0;
      poly_q <= '0;
      cnt    <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc <= acc_nx;
        opb <= opb << 1;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= sel;
        end
      end else if (start) begin
        op_q   <= op;
        m_q    <= deg_eff;
        poly_q <= poly_in;
        acc    <= '0;
        case (op)
          OP_LO, OP_HI, OP_REV: begin
            busy <= 1'b1;
            cnt  <= CW'(XLEN);
            opa  <= a;
            opb  <= b;
          end
          OP_GFMUL: begin
            busy <= 1'b1;
            cnt  <= CW'(deg_eff);
            opa  <= XLEN'(red_a);
            opb  <= XLEN'(red_b) << (CW'(XLEN) - CW'(deg_eff));
          end
          OP_GFADD: begin
            done   <= 1'b1;
            result <= XLEN'(gf_reduce(a[GFIN-1:0] ^ b[GFIN-1:0], deg_eff, poly_in));
          end
          default: begin
            done   <= 1'b1;
            result <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/polymul_unit_chk.sv
module polymul_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [2:0]      op,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  assert_busy_ends_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_oneshot_ops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op >= 3'd4) |=> (done && !busy));

  assert_multiply_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op <= 3'd3) |=> (busy && !done));
endmodule

bind polymul_unit polymul_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op),
  .busy(busy), .done(done), .result(result)
);

// File: tb/sim_polymul_unit.sv
`timescale 1ns/1ps
module sim_polymul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic [8:0]  modulus = '0;
  logic [3:0]  degree = '0;
  logic        busy, done;
  logic [63:0] result;

  int compared = 0;
  int mismatched = 0;
  logic [63:0] rs = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  polymul_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .modulus(modulus), .degree(degree), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  function automatic logic [127:0] cl_ref(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] p = '0;
    for (int i = 0; i < 64; i++) if (y[i]) p = p ^ ({64'b0, x} << i);
    return p;
  endfunction

  function automatic int eff_m(input logic [3:0] dg);
    return (dg == 0 || dg > 8) ? 8 : int'(dg);
  endfunction

  function automatic logic [31:0] gf_div(input logic [31:0] v, input logic [8:0] md, input logic [3:0] dg);
    int m = eff_m(dg);
    logic [31:0] p = (32'(md) & ((32'd1 << m) - 1)) | (32'd1 << m);
    for (int i = 31; i >= m; i--) if (v[i]) v = v ^ (p << (i - m));
    return v;
  endfunction

  function automatic logic [63:0] gfmul_ref(input logic [63:0] x, input logic [63:0] y,
                                           input logic [8:0] md, input logic [3:0] dg);
    logic [31:0] p = '0;
    for (int i = 0; i < 16; i++) if (y[i]) p = p ^ (32'(x[15:0]) << i);
    return 64'(gf_div(p, md, dg));
  endfunction

  function automatic logic [63:0] gfadd_ref(input logic [63:0] x, input logic [63:0] y,
                                           input logic [8:0] md, input logic [3:0] dg);
    return 64'(gf_div(32'(x[15:0] ^ y[15:0]), md, dg));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [63:0] x, input logic [63:0] y,
                        input logic [8:0] md, input logic [3:0] dg,
                        input logic [63:0] exp_r, input int exp_l, input string tag);
    int lat;
    @(negedge clk);
    op = o; a = x; b = y; modulus = md; degree = dg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(result == exp_r, {tag, " result"}, result, exp_r);
    check(lat == exp_l, {tag, " latency"}, 64'(lat), 64'(exp_l));
    @(negedge clk);
    check(!done && result == exp_r, "R8 done pulse/hold", {63'b0, done}, 64'b0);
  endtask

  initial begin
    #1000000;
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [63:0] x, y;
    logic [8:0]  md;
    int lat;
    repeat (3) @(negedge clk);
    check(!busy && !done && result == 64'b0, "R9 reset state", result, 64'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && result == 64'b0, "R9 after release", result, 64'b0);

    // R4 named examples
    run_op(3'd3, 64'd7, 64'd5, 9'h00B, 4'd3, 64'd6, 4, "R4 gf3 7*5");
    run_op(3'd3, 64'h80, 64'h83, 9'h11B, 4'd8, 64'h01, 9, "R4 aes 80*83");

    // R1 R2 R3 carry-less patterns
    for (int k = 0; k < 36; k++) begin
      logic [127:0] p;
      case (k)
        0: begin x = '0; y = '0; end
        1: begin x = '1; y = '1; end
        2: begin x = 64'd1; y = rnd(); end
        3: begin x = 64'h8000000000000000; y = 64'h8000000000000000; end
        default: begin x = rnd(); y = rnd(); end
      endcase
      p = cl_ref(x, y);
      run_op(3'd0, x, y, 9'h0, 4'd0, p[63:0],   65, "R1 clmul low");
      run_op(3'd1, x, y, 9'h0, 4'd0, p[127:64], 65, "R2 clmul high");
      run_op(3'd2, x, y, 9'h0, 4'd0, p[126:63], 65, "R3 clmul window");
    end

    // R4 exhaustive small fields
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_op(3'd3, 64'(i), 64'(j), 9'h00B, 4'd3,
               gfmul_ref(64'(i), 64'(j), 9'h00B, 4'd3), 4, "R4 gf3 sweep");
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        x = {rnd() & 64'hFFFF_FFFF_FFFF_0000} | 64'(i);
        y = {rnd() & 64'hFFFF_FFFF_FFFF_0000} | 64'(j);
        run_op(3'd3, x, y, 9'h013, 4'd4, gfmul_ref(x, y, 9'h013, 4'd4), 5, "R4 gf4 sweep");
      end
    // R4 unreduced 16-bit operands in the AES field
    for (int k = 0; k < 100; k++) begin
      x = rnd(); y = rnd();
      run_op(3'd3, x, y, 9'h11B, 4'd8, gfmul_ref(x, y, 9'h11B, 4'd8), 9, "R4 gf8 reduce-first");
    end
    // R6 every degree, random modulus bits
    for (int d = 1; d <= 8; d++)
      for (int k = 0; k < 20; k++) begin
        x = rnd(); y = rnd(); md = rnd();
        run_op(3'd3, x, y, md, 4'(d), gfmul_ref(x, y, md, 4'(d)), d + 1, "R6 degree/modulus");
      end
    run_op(3'd3, 64'h80, 64'h83, 9'h11B, 4'd0,  64'h01, 9, "R6 degree 0 as 8");
    run_op(3'd3, 64'h80, 64'h83, 9'h01B, 4'd12, 64'h01, 9, "R6 degree 12 as 8, bit m implied");
    run_op(3'd3, 64'd7, 64'd5, 9'h1FB, 4'd3, 64'd6, 4, "R6 upper modulus bits ignored");

    // R5 field add and pure reduction
    run_op(3'd4, 64'd0, 64'h11B, 9'h11B, 4'd8, 64'd0, 1, "R5 reduce modulus to zero");
    for (int k = 0; k < 200; k++) begin
      x = (k < 100) ? 64'd0 : rnd();
      y = rnd(); md = rnd();
      run_op(3'd4, x, y, md, 4'(1 + k % 8), gfadd_ref(x, y, md, 4'(1 + k % 8)), 1, "R5 gf add");
    end

    // R10 reserved codes
    for (int o = 5; o < 8; o++) begin
      run_op(3'd0, 64'd3, 64'd3, 9'h0, 4'd0, 64'd5, 65, "R1 preload");
      run_op(3'(o), rnd(), rnd(), 9'h11B, 4'd8, 64'd0, 1, "R10 reserved op");
    end

    // R7 start while busy
    x = rnd(); y = rnd();
    @(negedge clk);
    op = 3'd0; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (5) begin @(negedge clk); lat++; end
    op = 3'd4; a = 64'd0; b = 64'h1; degree = 4'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat++;
    while (!done && lat < 100) begin
      if (!busy) break;
      @(negedge clk);
      lat++;
    end
    check(lat == 65, "R7 latency unchanged", 64'(lat), 64'd65);
    check(result == cl_ref(x, y)[63:0], "R7 result kept", result, cl_ref(x, y)[63:0]);
    @(negedge clk);
    check(!done && !busy, "R7 no extra done", {62'b0, busy, done}, 64'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule